// File: doc/BRIEF.md
# Link-Layer Packet Transmitter with Go-Back-N Replay

This block sits on the transmit side of a packet link layer. The upper layer hands it one transaction packet at a time as a byte stream with valid/ready and start/end markers. The block numbers each packet and puts a two-byte sequence field in front of it. It appends a 32-bit link CRC. It keeps the whole framed packet in a slot of its replay store and sends it on the outgoing byte stream.

Decoded acknowledgements come back from the far end as a sequence number with an ACK/NAK flag. The acknowledgement is cumulative: an ACK frees the named packet and every older one. A NAK, or a replay timer that expires with packets still outstanding, causes every unacknowledged packet to be sent again in its original order. While a replay is pending or running, the upper layer is held off. New packets also stall when every slot holds an unacknowledged packet.

Top module: `tlp_replay_tx`

## Requirements
- R1: After reset the first packet gets sequence 0 and each new packet gets the previous number plus one. The frame begins with two header bytes: `{4'b0000, seq[11:8]}` and then `seq[7:0]`.
- R2: The four bytes after the payload are a CRC-32 over the header and payload bytes. The CRC is computed LSB-first with reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. Its least significant byte goes out first.
- R3: An outgoing frame is header, payload and CRC, so it is payload length + 6 bytes long. `out_sop` marks the first header byte and `out_eop` marks the last CRC byte. While `out_ready` is low, the presented byte and its markers hold.
- R4: An ACK carrying sequence N, with N among the sent and still-held packets, frees N and all older held packets. None of them is sent again.
- R5: A NAK carrying sequence N, with N in the same window, frees the packets older than N. It then resends N and every later sent packet in the original order.
- R6: When no acknowledgement makes progress for TIMEOUT cycles while sent packets are held, all held sent packets are resent in order. The first resent header byte is presented TIMEOUT+2 clock edges after the edge that completed the last transmission.
- R7: When SLOTS packets are held, no new packet is accepted (`in_ready` stays low) until an ACK frees a slot.
- R8: An ACK or NAK whose sequence number, measured modulo 4096 from the oldest held packet, is not below the number of sent held packets has no effect.
- R9: The replay timer restarts on every completed transmission and on every ACK that frees packets. It is stopped while nothing sent is held, so no replay ever starts from an empty window.
- R10: From a NAK or timeout until the last resent packet is completed, `in_ready` is low.
- R11: Sequence numbers wrap from 4095 to 0 with no change in behaviour. All window comparisons are modulo 4096.
- R12: During and directly after reset, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upper-layer byte valid |
| in_ready | output | 1 | Block accepts the upper-layer byte |
| in_data | input | 8 | Upper-layer payload byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Outgoing byte valid |
| out_ready | input | 1 | Downstream accepts the outgoing byte |
| out_data | output | 8 | Outgoing framed byte |
| out_sop | output | 1 | First byte of an outgoing frame |
| out_eop | output | 1 | Last byte of an outgoing frame |
| ack_valid | input | 1 | Acknowledgement present this cycle |
| ack_nak | input | 1 | 1 = NAK, 0 = ACK |
| ack_seq | input | 12 | Sequence number carried by the acknowledgement |

## Verification
A packet is framed into its slot first. Its header byte comes out two edges after the last CRC byte is written, and the upper layer sees ready in the payload phase, three edges after it presents the start byte. The bench does not depend on those input-side latencies: it drives payload only against `in_ready` sampled at the falling edge. A monitor records every outgoing byte and stamps the cycle of each frame's first and last byte. The one result with an exact due cycle is the timer-driven replay, and the bench checks that the replayed start byte arrives exactly TIMEOUT+3 monitor cycles after the last end byte was sampled. For effects that must not happen (ignored acknowledgements, blocked input, no replay from an empty window), the bench waits a bounded number of cycles and then checks frame counts, `in_ready` and the content of later frames.

// File: rtl/tlp_replay_tx.sv
module tlp_replay_tx #(
  parameter int SLOTS      = 4,
  parameter int SLOT_BYTES = 64,
  parameter int TIMEOUT    = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop,
  input  logic        ack_valid,
  input  logic        ack_nak,
  input  logic [11:0] ack_seq
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BYTES);
  localparam int TW = $clog2(TIMEOUT);
  localparam logic [11:0] SLOTS12 = 12'(SLOTS);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  typedef enum logic [1:0] {I_IDLE, I_HDR, I_PAY, I_CRC} ist_t;

  logic [7:0]    mem  [SLOTS*SLOT_BYTES];
  logic [BW-1:0] plen [SLOTS];

  ist_t          ist;
  logic [1:0]    sub;
  logic [BW-1:0] wr_idx, rd_idx;
  logic [31:0]   crc;
  logic [11:0]   next_seq, tx_seq, sent_end, una, cur;
  logic          tx_busy, replay_req;
  logic [TW-1:0] tmr;
  logic [7:0]    wdat;
  logic          we;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire [11:0] held     = next_seq - una;
  wire [11:0] sent_win = sent_end - una;
  wire [11:0] ack_off  = ack_seq - una;
  wire [11:0] tx_off   = tx_seq - una;
  wire        ack_ok   = ack_valid && (ack_off < sent_win);
  wire        progress = ack_ok && !ack_nak;
  wire        hold     = replay_req || (tx_seq != sent_end);
  wire        full     = held >= SLOTS12;
  wire        behind   = tx_off > held;
  wire        sent_done = tx_busy && out_ready && out_eop;
  wire [31:0] crc_out  = ~crc;

  assign in_ready  = (ist == I_PAY) && !hold;
  assign out_valid = tx_busy;
  assign out_data  = mem[{cur[SW-1:0], rd_idx}];
  assign out_sop   = rd_idx == '0;
  assign out_eop   = rd_idx == plen[cur[SW-1:0]];

  always_comb begin
    case (ist)
      I_HDR:   wdat = sub[0] ? next_seq[7:0] : {4'h0, next_seq[11:8]};
      I_CRC:   wdat = crc_out[8*sub +: 8];
      default: wdat = in_data;
    endcase
    we = (ist == I_HDR) || (ist == I_CRC) || (in_valid && in_ready);
  end

  always_ff @(posedge clk) begin
    if (we) mem[{next_seq[SW-1:0], wr_idx}] <= wdat;
    if (ist == I_CRC && sub == 2'd3) plen[next_seq[SW-1:0]] <= wr_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist      <= I_IDLE;
      sub      <= '0;
      wr_idx   <= '0;
      crc      <= '1;
      next_seq <= '0;
    end else begin
      case (ist)
        I_IDLE: if (in_valid && in_sop && !full && !hold) begin
          ist    <= I_HDR;
          sub    <= '0;
          wr_idx <= '0;
          crc    <= '1;
        end
        I_HDR: begin
          crc    <= crc_step(crc, wdat);
          wr_idx <= wr_idx + 1'b1;
          sub    <= sub + 1'b1;
          if (sub[0]) ist <= I_PAY;
        end
        I_PAY: if (in_valid && in_ready) begin
          crc    <= crc_step(crc, wdat);
          wr_idx <= wr_idx + 1'b1;
          if (in_eop) begin
            ist <= I_CRC;
            sub <= '0;
          end
        end
        I_CRC: begin
          sub <= sub + 1'b1;
          if (sub == 2'd3) begin
            ist      <= I_IDLE;
            next_seq <= next_seq + 1'b1;
          end else begin
            wr_idx <= wr_idx + 1'b1;
          end
        end
        default: ist <= I_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy    <= 1'b0;
      tx_seq     <= '0;
      sent_end   <= '0;
      una        <= '0;
      cur        <= '0;
      rd_idx     <= '0;
      replay_req <= 1'b0;
      tmr        <= '0;
    end else begin
      if (tx_busy) begin
        if (out_ready) begin
          rd_idx <= rd_idx + 1'b1;
          if (out_eop) begin
            tx_busy <= 1'b0;
            tx_seq  <= cur + 1'b1;
            if (cur == sent_end) sent_end <= cur + 1'b1;
          end
        end
      end else if (replay_req) begin
        tx_seq     <= una;
        replay_req <= 1'b0;
      end else if (behind) begin
        tx_seq <= una;
      end else if (tx_seq != next_seq) begin
        tx_busy <= 1'b1;
        cur     <= tx_seq;
        rd_idx  <= '0;
      end

      if (ack_ok) begin
        una <= ack_nak ? ack_seq : ack_seq + 1'b1;
        if (ack_nak) replay_req <= 1'b1;
      end

      if (sent_done || progress || sent_end == una) begin
        tmr <= '0;
      end else if (tmr == TLAST) begin
        tmr        <= '0;
        replay_req <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlp_replay_tx_chk.sv
module tlp_replay_tx_chk #(
  parameter int SLOTS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sop,
  input logic        out_eop,
  input logic        ack_valid,
  input logic        ack_nak,
  input logic [11:0] ack_seq,
  input logic [11:0] una,
  input logic [11:0] sent_end,
  input logic [11:0] next_seq,
  input logic        replay_req
);
  localparam logic [11:0] SLOTS12 = 12'(SLOTS);
  wire [11:0] held_c = next_seq - una;
  wire [11:0] off_c  = ack_seq - una;
  wire [11:0] win_c  = sent_end - una;
  wire        in_win = off_c < win_c;

  p_hdr_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data[7:4] == 4'h0);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_nak && in_win |=> una == 12'($past(ack_seq) + 12'd1));

  p_window_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held_c <= SLOTS12);

  p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !in_win |=> una == $past(una));

  p_no_empty_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_req) |-> $past(sent_end != una));

  p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> !in_ready);
endmodule

bind tlp_replay_tx tlp_replay_tx_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
  .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq), .una(una),
  .sent_end(sent_end), .next_seq(next_seq), .replay_req(replay_req)
);

// File: tb/tb_tlp_replay_tx.sv
module tb_tlp_replay_tx;
  localparam int TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic ack_valid = 0, ack_nak = 0;
  logic [11:0] ack_seq = '0;

  always #10 clk = ~clk;

  tlp_replay_tx #(.SLOTS(4), .SLOT_BYTES(64), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq));

  int checks = 0, fails = 0, cyc = 0, rx_count = 0, cur_len = 0;
  logic [7:0] rxb [64][64];
  int rxl [64], sop_cyc [64], eop_cyc [64];
  bit ir_hi [64];
  logic [7:0] expb [64];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_sop) begin
        cur_len = 0;
        sop_cyc[rx_count % 64] = cyc;
        ir_hi[rx_count % 64] = 0;
      end
      if (cur_len < 64) rxb[rx_count % 64][cur_len] = out_data;
      cur_len++;
      if (in_ready) ir_hi[rx_count % 64] = 1;
      if (out_eop) begin
        rxl[rx_count % 64] = cur_len;
        eop_cyc[rx_count % 64] = cyc;
        rx_count++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, expb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic chk_pkt(input int idx, input int seq, input int n, input int base, input string req);
    int k, bad;
    logic [31:0] c;
    k = idx % 64;
    bad = -1;
    expb[0] = {4'h0, 4'(seq >> 8)};
    expb[1] = 8'(seq);
    for (int i = 0; i < n; i++) expb[2 + i] = 8'(base + i);
    c = crc_of(n + 2);
    for (int j = 0; j < 4; j++) expb[n + 2 + j] = c[8*j +: 8];
    checks++;
    if (rxl[k] != n + 6) begin
      fails++;
      $display("FAIL %s: frame %0d length actual %0d expected %0d", req, idx, rxl[k], n + 6);
    end else begin
      for (int i = 0; i < n + 6; i++) if (bad < 0 && rxb[k][i] != expb[i]) bad = i;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s: frame %0d byte %0d actual %02h expected %02h",
                 req, idx, bad, rxb[k][bad], expb[bad]);
      end
    end
  endtask

  task automatic send_pkt(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      in_data = 8'(base + i);
      in_sop = (i == 0);
      in_eop = (i == n - 1);
      in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_ack(input bit nak, input int seq);
    ack_valid = 1; ack_nak = nak; ack_seq = 12'(seq);
    @(negedge clk);
    ack_valid = 0; ack_nak = 0;
  endtask

  task automatic wait_rx(input int target, input string req);
    int w;
    w = 0;
    while (rx_count < target && w < 3000) begin @(negedge clk); w++; end
    if (rx_count < target) check(0, req, rx_count, target);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(3);
    check(out_valid == 0, "R12 out_valid", out_valid, 0);
    check(in_ready == 0, "R12 in_ready", in_ready, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 0, "R12 after release", out_valid, 0);
  endtask

  task automatic t_basic;
    send_pkt(4, 8'h10);
    wait_rx(1, "R3 first frame");
    chk_pkt(0, 0, 4, 8'h10, "R1 R2 R3 seq0");
  endtask

  task automatic t_multi;
    send_pkt(7, 8'h30);
    send_pkt(1, 8'h50);
    wait_rx(3, "R1 frames");
    chk_pkt(1, 1, 7, 8'h30, "R1 R2 seq1");
    chk_pkt(2, 2, 1, 8'h50, "R1 R2 seq2");
  endtask

  task automatic t_ack_nak;
    send_ack(0, 1);
    send_ack(1, 2);
    wait_rx(4, "R5 replay");
    chk_pkt(3, 2, 1, 8'h50, "R5 replay from seq2");
    idle(20);
    check(rx_count == 4, "R4 released frames not resent", rx_count, 4);
    send_ack(0, 2);
    idle(10);
    check(rx_count == 4, "R4 no traffic after ack", rx_count, 4);
  endtask

  task automatic t_window;
    send_pkt(3, 8'h70);
    wait_rx(5, "R8 seq3");
    chk_pkt(4, 3, 3, 8'h70, "R1 seq3");
    send_ack(0, 7);
    send_ack(0, 2);
    send_ack(1, 9);
    idle(5);
    check(rx_count == 5, "R8 stray nak ignored", rx_count, 5);
    send_ack(1, 3);
    wait_rx(6, "R8 nak after strays");
    chk_pkt(5, 3, 3, 8'h70, "R8 window intact");
    send_ack(0, 3);
  endtask

  task automatic t_full;
    int hi;
    hi = 0;
    for (int s = 4; s < 8; s++) send_pkt(2, 8'(s * 16));
    wait_rx(10, "R7 four frames");
    chk_pkt(9, 7, 2, 8'h70, "R7 seq7");
    in_data = 8'h90; in_sop = 1; in_eop = 0; in_valid = 1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (in_ready) hi = 1;
    end
    check(hi == 0, "R7 in_ready while full", hi, 0);
    check(rx_count == 10, "R7 nothing new sent", rx_count, 10);
    send_ack(0, 5);
    send_pkt(2, 8'h90);
    wait_rx(11, "R7 after free");
    chk_pkt(10, 8, 2, 8'h90, "R7 seq8 after ack");
    send_ack(0, 8);
  endtask

  task automatic t_timeout;
    send_pkt(2, 8'hA0);
    send_pkt(3, 8'hB0);
    wait_rx(13, "R6 frames");
    wait_rx(15, "R6 replay");
    chk_pkt(13, 9, 2, 8'hA0, "R6 replay seq9");
    chk_pkt(14, 10, 3, 8'hB0, "R6 replay seq10");
    check(sop_cyc[13] - eop_cyc[12] == TMO + 3, "R6 replay timing",
          sop_cyc[13] - eop_cyc[12], TMO + 3);
    send_ack(0, 10);
  endtask

  task automatic t_idle_timer;
    idle(3 * TMO);
    check(rx_count == 15, "R9 no replay when empty", rx_count, 15);
  endtask

  task automatic t_holdoff;
    send_pkt(4, 8'hC0);
    send_pkt(4, 8'hD0);
    wait_rx(17, "R10 frames");
    fork
      send_pkt(20, 8'h01);
      begin idle(6); send_ack(1, 11); end
    join
    wait_rx(20, "R10 ordering");
    chk_pkt(17, 11, 4, 8'hC0, "R10 replay seq11");
    chk_pkt(18, 12, 4, 8'hD0, "R10 replay seq12");
    chk_pkt(19, 13, 20, 8'h01, "R10 new seq13 after replay");
    check(ir_hi[17] == 0 && ir_hi[18] == 0, "R10 in_ready low during replay",
          int'(ir_hi[17]) + int'(ir_hi[18]), 0);
    send_ack(0, 13);
  endtask

  task automatic t_wrap;
    for (int s = 14; s < 4098; s++) begin
      send_pkt(1, s & 255);
      wait_rx(rx_count + 1, "R11 stream");
      if (s >= 4095) chk_pkt(rx_count - 1, s % 4096, 1, s & 255, "R11 wrap");
      send_ack(0, s % 4096);
    end
    send_ack(1, 1);
    idle(10);
    check(rx_count == 20 + 4084, "R11 stale nak after wrap ignored", rx_count, 20 + 4084);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_multi();
    t_ack_nak();
    t_window();
    t_full();
    t_timeout();
    t_idle_timer();
    t_holdoff();
    t_wrap();
    idle(5);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end
endmodule